// File: doc/BRIEF.md
# Multi-Lane Link Training Pattern Generator

This block sits just ahead of the serialisers of a four-lane fixed-rate link. While training is in progress, each lane sends a test pattern. The pattern for each lane is picked by its own 4-bit code inside a 16-bit selector word. When the link is up, each lane carries the 40-bit payload word supplied for it. A 4-bit rate code sets how many lanes are in use. Lanes that are not in use are held at zero.

There are three kinds of training pattern. Fixed words cover all ones, all zeros, an alternating Nyquist clock and a compliance square wave. Four pseudo-random sequences are also available, and every lane runs its own LFSR. Each output is a register, so every lane word appears one clock after the inputs that choose it.

Top module: `frl_pat_gen`

## Requirements
- R1: While `rst` is high, all four lane outputs are zero.
- R2: When `linkUp` is 1, each active lane outputs the payload word that was on its data input at the previous clock edge.
- R3: The selector for lane k is `patSel[4k+3:4k]`, for k = 0 to 3. Each lane's pattern depends only on its own field.
- R4: During training (`linkUp` = 0), on an active lane, code 1 gives all ones, and codes 0 and 2 give all zeros.
- R5: During training, code 3 gives 40'hAAAAAAAAAA (alternating bits), and code 4 gives 40'hFFFFF00000 (20 ones above 20 zeros).
- R6: Codes 5, 6, 7 and 8 output a 16-bit Fibonacci LFSR with feedback s[15]^s[4]^s[3]^s[2] (x^16+x^5+x^4+x^3+1). It shifts left and takes the feedback into bit 0. Each output bit is s[15] before a step. Word bit 0 is the first bit generated, and there are 40 steps per clock. The seeds for codes 5, 6, 7 and 8 are 16'hACE1, 16'h1D0F, 16'h5A5A and 16'hB00B.
- R7: When a lane's code differs from its code at the previous edge, that lane's LFSR reloads the seed of the new code. The reloaded word is output at that edge. Otherwise the lane's LFSR advances 40 steps on every clock, in any mode and at any rate. After reset, the previous code is taken as 0 and the LFSR state as zero.
- R8: Rate codes 1 and 2 activate lanes 0 to 2 and force lane 3 to zero. Rate codes 3 to 6 activate all four lanes. Rate codes 0 and 7 to 15 force all lanes to zero in both modes.
- R9: Selector codes 9 to 15 produce all zeros on an active lane during training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst | input | 1 | Asynchronous reset, active high |
| linkUp | input | 1 | 1 sends payload, 0 sends training patterns |
| rateCode | input | 4 | Sets the number of active lanes |
| patSel | input | 16 | Four 4-bit per-lane pattern selectors |
| dataLane0 | input | 40 | Payload word for lane 0 |
| dataLane1 | input | 40 | Payload word for lane 1 |
| dataLane2 | input | 40 | Payload word for lane 2 |
| dataLane3 | input | 40 | Payload word for lane 3 |
| outLane0 | output | 40 | Lane 0 output word |
| outLane1 | output | 40 | Lane 1 output word |
| outLane2 | output | 40 | Lane 2 output word |
| outLane3 | output | 40 | Lane 3 output word |

## Verification
The hardest state to reach from the ports is an LFSR that has been running for a long time after its seed was loaded. Its phase depends on every clock since its code last changed, including clocks spent in payload mode or on an inactive lane. The stimulus sweeps every rate code with both modes. It steps the four selector fields through all sixteen codes, each lane offset from the next, and holds each setting for several clocks. It then keeps one selector word fixed while toggling the mode, so that the sequence must carry on without a break. A reset in the middle of the run checks that the seed reload behaves the same as after the first reset.

// File: rtl/frl_pat_pkg.sv
package frl_pat_pkg;
  localparam int LANES  = 4;
  localparam int WORD_W = 40;
  localparam int SEL_W  = 4;
  localparam int LFSR_W = 16;
  localparam int RATE_W = 4;

  typedef enum logic [2:0] {
    M_ZERO, M_DATA, M_ONES, M_NYQ, M_CMP, M_LFSR
  } laneMode_e;

  // per-lane strobes from control to datapath
  typedef struct packed {
    laneMode_e          mode;
    logic               reload;
    logic [SEL_W-1:0]   sel;
  } laneCtl_t;

  function automatic logic [LFSR_W-1:0] seedOf(input logic [SEL_W-1:0] sel);
    case (sel)
      4'd5:    seedOf = 16'hACE1;
      4'd6:    seedOf = 16'h1D0F;
      4'd7:    seedOf = 16'h5A5A;
      4'd8:    seedOf = 16'hB00B;
      default: seedOf = '0;
    endcase
  endfunction

  function automatic int activeLanes(input logic [RATE_W-1:0] rate);
    if (rate == 4'd1 || rate == 4'd2)       activeLanes = 3;
    else if (rate >= 4'd3 && rate <= 4'd6)  activeLanes = 4;
    else                                    activeLanes = 0;
  endfunction
endpackage

// File: rtl/frl_pat_ctrl.sv
module frl_pat_ctrl
  import frl_pat_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int SELW  = SEL_W,
  parameter int RATEW = RATE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    linkUp,
  input  logic [RATEW-1:0]        rateCode,
  input  logic [NLANE*SELW-1:0]   patSel,
  output laneCtl_t [NLANE-1:0]    ctl
);
  int nAct;
  assign nAct = activeLanes(rateCode);

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [SELW-1:0] sel;
    logic [SELW-1:0] prevSel;
    laneMode_e       mode;

    assign sel = patSel[k*SELW +: SELW];

    always_ff @(posedge clk or posedge rst) begin
      if (rst) prevSel <= '0;
      else     prevSel <= sel;
    end

    always_comb begin
      if (k >= nAct)   mode = M_ZERO;
      else if (linkUp) mode = M_DATA;
      else begin
        case (sel)
          4'd1:                 mode = M_ONES;
          4'd3:                 mode = M_NYQ;
          4'd4:                 mode = M_CMP;
          4'd5, 4'd6, 4'd7, 4'd8: mode = M_LFSR;
          default:              mode = M_ZERO;
        endcase
      end
    end

    assign ctl[k].mode   = mode;
    assign ctl[k].reload = (sel != prevSel);
    assign ctl[k].sel    = sel;
  end
endmodule

// File: rtl/frl_pat_dp.sv
module frl_pat_dp
  import frl_pat_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int WW    = WORD_W,
  parameter int LW    = LFSR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  laneCtl_t [NLANE-1:0]  ctl,
  input  logic [NLANE*WW-1:0]   dataIn,
  output logic [NLANE*WW-1:0]   laneOut
);
  localparam logic [LW-1:0] TAPS     = 16'h801C;
  localparam logic [WW-1:0] NYQ_WORD = {(WW/2){2'b10}};
  localparam logic [WW-1:0] CMP_WORD = {{(WW/2){1'b1}}, {(WW/2){1'b0}}};

  // returns {next state, emitted word}
  function automatic logic [LW+WW-1:0] runLfsr(input logic [LW-1:0] s0);
    logic [LW-1:0] s;
    logic [WW-1:0] w;
    s = s0;
    w = '0;
    for (int i = 0; i < WW; i++) begin
      w[i] = s[LW-1];
      s    = {s[LW-2:0], ^(s & TAPS)};
    end
    return {s, w};
  endfunction

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [LW-1:0] st;
    logic [LW-1:0] cur;
    logic [LW-1:0] nxt;
    logic [WW-1:0] prbs;
    logic [WW-1:0] word;

    assign cur         = ctl[k].reload ? seedOf(ctl[k].sel) : st;
    assign {nxt, prbs} = runLfsr(cur);

    always_comb begin
      case (ctl[k].mode)
        M_DATA:  word = dataIn[k*WW +: WW];
        M_ONES:  word = '1;
        M_NYQ:   word = NYQ_WORD;
        M_CMP:   word = CMP_WORD;
        M_LFSR:  word = prbs;
        default: word = '0;
      endcase
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        st                  <= '0;
        laneOut[k*WW +: WW] <= '0;
      end else begin
        st                  <= nxt;
        laneOut[k*WW +: WW] <= word;
      end
    end
  end
endmodule

// File: rtl/frl_pat_gen.sv
module frl_pat_gen
  import frl_pat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              linkUp,
  input  logic [RATE_W-1:0] rateCode,
  input  logic [15:0]       patSel,
  input  logic [WORD_W-1:0] dataLane0,
  input  logic [WORD_W-1:0] dataLane1,
  input  logic [WORD_W-1:0] dataLane2,
  input  logic [WORD_W-1:0] dataLane3,
  output logic [WORD_W-1:0] outLane0,
  output logic [WORD_W-1:0] outLane1,
  output logic [WORD_W-1:0] outLane2,
  output logic [WORD_W-1:0] outLane3
);
  laneCtl_t [LANES-1:0]     ctl;
  logic [LANES*WORD_W-1:0]  dataIn;
  logic [LANES*WORD_W-1:0]  laneOut;

  assign dataIn = {dataLane3, dataLane2, dataLane1, dataLane0};

  frl_pat_ctrl u_ctrl (
    .clk(clk), .rst(rst), .linkUp(linkUp), .rateCode(rateCode),
    .patSel(patSel), .ctl(ctl)
  );

  frl_pat_dp u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .dataIn(dataIn), .laneOut(laneOut)
  );

  assign {outLane3, outLane2, outLane1, outLane0} = laneOut;
endmodule

// File: rtl/frl_pat_chk.sv
module frl_pat_chk (
  input logic        clk,
  input logic        rst,
  input logic        linkUp,
  input logic [3:0]  rateCode,
  input logic [3:0]  sel0,
  input logic [3:0]  sel1,
  input logic [39:0] dataLane0,
  input logic [39:0] outLane0,
  input logic [39:0] outLane1,
  input logic [39:0] outLane2,
  input logic [39:0] outLane3
);
  logic armed;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2
  lane0_pass_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(linkUp) && $past(rateCode) >= 4'd1 && $past(rateCode) <= 4'd6
    |-> outLane0 == $past(dataLane0));

  // R8
  lane3_idle_chk: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(rateCode) == 4'd1 || $past(rateCode) == 4'd2)
    |-> outLane3 == '0);

  // R8
  link_off_chk: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(rateCode) == 4'd0 || $past(rateCode) > 4'd6)
    |-> (outLane0 | outLane1 | outLane2 | outLane3) == '0);

  // R4
  lane0_ones_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(linkUp) && $past(rateCode) >= 4'd1 && $past(rateCode) <= 4'd6
    && $past(sel0) == 4'd1 |-> outLane0 == '1);

  // R5
  lane1_nyq_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(linkUp) && $past(rateCode) >= 4'd1 && $past(rateCode) <= 4'd6
    && $past(sel1) == 4'd3 |-> outLane1 == 40'hAAAAAAAAAA);
endmodule

bind frl_pat_gen frl_pat_chk u_chk (
  .clk(clk), .rst(rst), .linkUp(linkUp), .rateCode(rateCode),
  .sel0(patSel[3:0]), .sel1(patSel[7:4]), .dataLane0(dataLane0),
  .outLane0(outLane0), .outLane1(outLane1), .outLane2(outLane2), .outLane3(outLane3)
);

// File: tb/frl_pat_gen_bench.sv
module frl_pat_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        linkUp = 1'b0;
  logic [3:0]  rateCode = '0;
  logic [15:0] patSel = '0;
  logic [39:0] dIn [4];
  logic [39:0] got [4];
  logic [39:0] exp [4];
  string       tag [4];
  logic [15:0] mSt [4];
  logic [3:0]  mPrev [4];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  frl_pat_gen u_frl_pat_gen (
    .clk(clk), .rst(rst), .linkUp(linkUp), .rateCode(rateCode), .patSel(patSel),
    .dataLane0(dIn[0]), .dataLane1(dIn[1]), .dataLane2(dIn[2]), .dataLane3(dIn[3]),
    .outLane0(got[0]), .outLane1(got[1]), .outLane2(got[2]), .outLane3(got[3])
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] seedFor(input logic [3:0] c);
    case (c)
      4'd5: return 16'hACE1;
      4'd6: return 16'h1D0F;
      4'd7: return 16'h5A5A;
      4'd8: return 16'hB00B;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input int k);
    total++;
    if (got[k] !== exp[k]) begin
      bad++;
      $display("FAIL %s lane %0d: got %h expected %h", tag[k], k, got[k], exp[k]);
    end
  endtask

  task automatic tick(input logic st, input logic [3:0] rt, input logic [15:0] pw);
    int nAct;
    linkUp = st; rateCode = rt; patSel = pw;
    for (int k = 0; k < 4; k++) dIn[k] = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
    nAct = (rt == 1 || rt == 2) ? 3 : ((rt >= 3 && rt <= 6) ? 4 : 0);
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      logic [3:0]  c;
      logic [15:0] s;
      logic [39:0] w;
      c = pw[4*k +: 4];                      // R3 field of lane k
      s = (c != mPrev[k]) ? seedFor(c) : mSt[k];  // R7 reload
      for (int i = 0; i < 40; i++) begin     // R6 sequence
        w[i] = s[15];
        s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
      end
      mSt[k] = s; mPrev[k] = c;
      if (k >= nAct) begin exp[k] = '0; tag[k] = "R8"; end
      else if (st) begin exp[k] = dIn[k]; tag[k] = "R2"; end
      else begin
        case (c)
          4'd1: begin exp[k] = '1; tag[k] = "R4 R3"; end
          4'd0, 4'd2: begin exp[k] = '0; tag[k] = "R4 R3"; end
          4'd3: begin exp[k] = 40'hAAAAAAAAAA; tag[k] = "R5 R3"; end
          4'd4: begin exp[k] = 40'hFFFFF00000; tag[k] = "R5 R3"; end
          4'd5, 4'd6, 4'd7, 4'd8: begin exp[k] = w; tag[k] = "R6 R7"; end
          default: begin exp[k] = '0; tag[k] = "R9"; end
        endcase
      end
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) check(k);
  endtask

  task automatic resetCheck();
    for (int k = 0; k < 4; k++) begin
      exp[k] = '0; tag[k] = "R1";
      mSt[k] = '0; mPrev[k] = '0;
      check(k);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) dIn[k] = '0;
    repeat (3) @(negedge clk);
    resetCheck();
    rst = 1'b0;
    // sweep every rate, both modes, every selector code with lanes offset
    for (int rt = 0; rt < 16; rt++)
      for (int st = 0; st < 2; st++)
        for (int s = 0; s < 16; s++) begin
          logic [3:0] a;
          a = 4'(s);
          repeat (3) tick(st[0], 4'(rt), {a + 4'd3, a + 4'd2, a + 4'd1, a});
        end
    // R7: long LFSR run, continuing through payload mode
    repeat (20) tick(1'b0, 4'd6, 16'h8765);
    repeat (5)  tick(1'b1, 4'd6, 16'h8765);
    repeat (5)  tick(1'b0, 4'd6, 16'h8765);
    // R1: reset in the middle of training
    rst = 1'b1;
    linkUp = 1'b0; rateCode = 4'd3; patSel = 16'h5678;
    repeat (2) @(negedge clk);
    resetCheck();
    rst = 1'b0;
    repeat (6) tick(1'b0, 4'd3, 16'h5678);
    repeat (4) tick(1'b0, 4'd2, 16'h4315);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule